// File: doc/BRIEF.md
# Reversible Full-Cycle LFSR Address Generator

This block produces memory addresses for a built-in self-test engine that runs march sequences. Instead of a binary up/down counter it uses a shift register with linear feedback, which visits every address exactly once per period in a scrambled order. A NOR term over part of the state patches the feedback so that the all-zero address is part of the cycle. The period is therefore the full 2^WIDTH rather than 2^WIDTH - 1.

A direction input picks one of two next-state functions for every flip-flop. Stepping up shifts toward the high bit using the forward polynomial x^3 + x + 1. Stepping down shifts toward the low bit using the reciprocal polynomial x^3 + x^2 + 1. The down order is therefore exactly the up order read backwards. A march element that must walk the address space in descending order only has to flip the direction input, and it can do so at any step.

The width and forward tap mask are parameters. The reverse tap mask is derived from the forward one, so the two functions stay exact inverses.

Top module: `updn_addr_lfsr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr` becomes 0 on that edge, whatever `en` and `up_dn` are.
- R2: When `en` is low at a rising edge and `rst` is low, `addr` keeps its value.
- R3: `addr` holds a state whose bit k is position k of the state string. With `en` high and `up_dn` = 1 (up), starting from 0 the values taken are 0, 1, 3, 7, 6, 5, 2, 4, and then 0 again.
- R4: With `en` high and `up_dn` = 0 (down), starting from 0 the values taken are 0, 4, 2, 5, 6, 7, 3, 1, and then 0 again.
- R5: An enabled step in one direction followed at once by an enabled step in the other direction returns `addr` to its value before the first step. This holds from every state.
- R6: Eight consecutive enabled steps in one direction visit each of the 8 values exactly once and return to the starting value.
- R7: The zero state lies inside the cycle. An up step from 4 gives 0 and an up step from 0 gives 1. A down step from 1 gives 0 and a down step from 0 gives 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads 0 |
| en | input | 1 | Step enable |
| up_dn | input | 1 | Direction: 1 steps up, 0 steps down |
| addr | output | WIDTH | Current generator state, used as the address |

## Verification
The hardest situation to reach is a direction change at each of the eight states, because a free run only shows each state with one neighbour in one direction. The bench resets and walks up k steps for every k from 0 to 7, then takes one step down. It repeats this with the roles of the two directions swapped, so every state is left backwards at least once. The zero state, which only the NOR patch puts in the cycle, is entered and left in both directions within these sweeps.

// File: rtl/updn_addr_pkg.sv
package updn_addr_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Reverse tap mask derived from the forward one so both functions are inverses.
    function automatic logic [31:0] reverse_mask(input logic [31:0] fwd, input int width);
        logic [31:0] r;
        r = 32'd1;
        for (int t = 0; t < width - 1; t++) begin
            if (fwd[t]) r[t+1] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/updn_addr_zero_nor.sv
module updn_addr_zero_nor #(
    parameter int NBITS = 2
) (
    input  logic [NBITS-1:0] bits_i,
    output logic             all_zero_o
);
    assign all_zero_o = ~(|bits_i);
endmodule

// File: rtl/updn_addr_fwd_next.sv
module updn_addr_fwd_next #(
    parameter int               WIDTH    = 3,
    parameter logic [WIDTH-1:0] FWD_MASK = 3'b101
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic zero_lo;

    // Low bits all clear: the outgoing bit alone decides, patch the feedback.
    updn_addr_zero_nor #(.NBITS(WIDTH-1)) u_nor (
        .bits_i     (cur_i[WIDTH-2:0]),
        .all_zero_o (zero_lo)
    );

    always_comb begin
        nxt_o[0]         = (^(cur_i & FWD_MASK)) ^ zero_lo;
        nxt_o[WIDTH-1:1] = cur_i[WIDTH-2:0];
    end
endmodule

// File: rtl/updn_addr_rev_next.sv
module updn_addr_rev_next #(
    parameter int               WIDTH    = 3,
    parameter logic [WIDTH-1:0] REV_MASK = 3'b011
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic zero_hi;

    updn_addr_zero_nor #(.NBITS(WIDTH-1)) u_nor (
        .bits_i     (cur_i[WIDTH-1:1]),
        .all_zero_o (zero_hi)
    );

    always_comb begin
        nxt_o[WIDTH-1]   = (^(cur_i & REV_MASK)) ^ zero_hi;
        nxt_o[WIDTH-2:0] = cur_i[WIDTH-1:1];
    end
endmodule

// File: rtl/updn_addr_lfsr.sv
module updn_addr_lfsr
    import updn_addr_pkg::*;
#(
    parameter int               WIDTH    = 3,
    parameter logic [WIDTH-1:0] FWD_MASK = 3'b101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             up_dn,
    output logic [WIDTH-1:0] addr
);
    localparam logic [31:0]      REV_FULL = reverse_mask(32'(FWD_MASK), WIDTH);
    localparam logic [WIDTH-1:0] REV_MASK = REV_FULL[WIDTH-1:0];

    typedef struct packed {
        logic [WIDTH-1:0] addr;
    } state_t;

    state_t state_d, state_q;
    logic [WIDTH-1:0] up_nxt, dn_nxt, step_nxt;
    dir_e dir;

    assign dir = dir_e'(up_dn);

    updn_addr_fwd_next #(.WIDTH(WIDTH), .FWD_MASK(FWD_MASK)) u_fwd (
        .cur_i (state_q.addr),
        .nxt_o (up_nxt)
    );

    updn_addr_rev_next #(.WIDTH(WIDTH), .REV_MASK(REV_MASK)) u_rev (
        .cur_i (state_q.addr),
        .nxt_o (dn_nxt)
    );

    // One 2:1 select per flip-flop between the two next-state functions.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit_mux
        assign step_nxt[b] = (dir == DIR_UP) ? up_nxt[b] : dn_nxt[b];
    end

    always_comb begin
        state_d = state_q;
        if (en) state_d.addr = step_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign addr = state_q.addr;
endmodule

// File: rtl/updn_addr_lfsr_chk.sv
module updn_addr_lfsr_chk #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             up_dn,
    input logic [WIDTH-1:0] addr
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> addr == '0);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(addr));

    // R5
    up_then_down_chk: assert property (@(posedge clk) disable iff (rst)
        (en && up_dn) ##1 (en && !up_dn) |=> addr == $past(addr, 2));

    // R5
    down_then_up_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !up_dn) ##1 (en && up_dn) |=> addr == $past(addr, 2));

    // R7
    zero_leave_up_chk: assert property (@(posedge clk) disable iff (rst)
        (en && up_dn && addr == '0) |=> addr == WIDTH'(1));

    // R7
    zero_leave_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !up_dn && addr == '0) |=> addr == WIDTH'(1 << (WIDTH-1)));

    // R6
    step_moves_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> addr != $past(addr));
endmodule

bind updn_addr_lfsr updn_addr_lfsr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .up_dn (up_dn),
    .addr  (addr)
);

// File: tb/updn_addr_lfsr_tb.sv
module updn_addr_lfsr_tb;
    logic clk = 1'b0;
    logic rst, en, up_dn;
    logic [2:0] addr;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int up_seq [8] = '{0, 1, 3, 7, 6, 5, 2, 4};

    always #2.5 clk = ~clk;

    updn_addr_lfsr u_dut (.clk(clk), .rst(rst), .en(en), .up_dn(up_dn), .addr(addr));

    function automatic int pos_of(input int v);
        for (int i = 0; i < 8; i++) if (up_seq[i] == v) return i;
        return -1;
    endfunction

    task automatic check(input string req, input int exp);
        n_cmp++;
        if (int'(addr) != exp) begin
            n_bad++;
            $display("FAIL %s: addr=%0d expected=%0d", req, addr, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic u);
        @(negedge clk);
        rst = r; en = e; up_dn = u;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; up_dn = 1'b1;
        do_reset();
        check("R1 reset", 0);
        step(1'b1, 1'b1, 1'b0);
        check("R1 reset over enable", 0);

        // R3 / R6 up sweep
        begin
            bit [7:0] seen = '0;
            for (int i = 1; i <= 8; i++) begin
                step(1'b0, 1'b1, 1'b1);
                check("R3 up order", up_seq[i % 8]);
                seen[addr] = 1'b1;
            end
            n_cmp++;
            if (seen != 8'hFF) begin
                n_bad++;
                $display("FAIL R6 up visits: seen=%h expected=ff", seen);
            end
        end

        // R4 / R6 down sweep
        begin
            bit [7:0] seen = '0;
            do_reset();
            for (int i = 1; i <= 8; i++) begin
                step(1'b0, 1'b1, 1'b0);
                check("R4 down order", up_seq[(8 - i) % 8]);
                seen[addr] = 1'b1;
            end
            n_cmp++;
            if (seen != 8'hFF) begin
                n_bad++;
                $display("FAIL R6 down visits: seen=%h expected=ff", seen);
            end
        end

        // R2 hold with both direction values
        do_reset();
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, i[0]);
            check("R2 hold", 3);
        end

        // R5 reversal at every state, both ways
        for (int k = 0; k < 8; k++) begin
            do_reset();
            for (int j = 0; j < k; j++) step(1'b0, 1'b1, 1'b1);
            step(1'b0, 1'b1, 1'b0);
            check("R5 up then down", up_seq[(k + 7) % 8]);
            step(1'b0, 1'b1, 1'b1);
            check("R5 back up", up_seq[k]);
        end
        for (int k = 0; k < 8; k++) begin
            do_reset();
            for (int j = 0; j < k; j++) step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b1, 1'b1);
            check("R5 down then up", up_seq[(8 - k + 1) % 8]);
        end

        // R7 zero entry and exit
        do_reset();
        for (int j = 0; j < 7; j++) step(1'b0, 1'b1, 1'b1);
        check("R7 at four", 4);
        step(1'b0, 1'b1, 1'b1);
        check("R7 up into zero", 0);
        step(1'b0, 1'b1, 1'b0);
        check("R7 down out of zero", 4);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        check("R7 up out of zero", 1);
        step(1'b0, 1'b1, 1'b0);
        check("R7 down into zero", 0);

        // R1 reset mid-run
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        check("R1 mid-run reset", 0);
        n_cmp++;
        if (pos_of(int'(addr)) != 0) begin
            n_bad++;
            $display("FAIL R1 position: pos=%0d expected=0", pos_of(int'(addr)));
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: done=0 expected=1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule